// File: doc/BRIEF.md
# Type 1 Bridge Configuration Front End

This block sits between a host configuration-access port and a root-port core whose own configuration header does not follow the standard Type 1 bridge layout. The host issues configuration reads and writes as bus, device, function, dword index, byte enables and write data. The block rejects addresses that cannot exist behind a point-to-point port. It keeps the bridge's window registers (byte offsets 0x10 to 0x33) in local shadow storage, so those accesses never reach the core. Every other access goes out to the core as an encoded address word, and read data coming back from the core is patched so that the host sees a compliant Type 1 bridge.

The core uses one local bus number and one local device number to classify requests. A request whose bus differs from the local bus goes out as Type 1. A request on the local bus with a different device goes out as Type 0. A request matching both goes to the internal root port. The block sets the local device number to 1 and keeps the local bus number equal to the secondary bus number that the host programs into the shadow bus-number dword. Host accesses to the bridge (device 0 on the tracked primary bus) are therefore rewritten to device 1 on the secondary bus. Requests for the expansion ROM base dword are moved to the offset where the core implements it.

Top module: `bridgeCfgFront`

## Requirements
- R1: A request whose bus equals the tracked primary bus is a bridge request and is legal only with device 0 and function 0. Otherwise, a request whose bus equals the secondary bus is legal only with device 0. All other buses are legal. An illegal read completes with rspRdata = 0xFFFFFFFF. An illegal write changes nothing. Neither kind reaches the core.
- R2: The only legal byte-enable patterns are 0001, 0010, 0100, 1000, 0011, 1100 and 1111. Any other pattern completes without side effects and without a core access, and a read returns 0xFFFFFFFF.
- R3: Legal bridge requests to dword indices 4 through 12 (bytes 0x10 to 0x33) are served from nine local 32-bit shadow registers and never reach the core. A write replaces only the enabled bytes.
- R4: Any write to shadow dword 4 or 5 stores zero.
- R5: A shadow write to dword 6 with byte enable 0 set loads the primary bus number from bits 7:0. With byte enable 1 set, it loads the secondary bus number from bits 15:8. localBusNum always shows the secondary bus number.
- R6: A legal bridge request to dword 14 (0x38) is sent to the core at dword 12 (0x30).
- R7: Other legal bridge requests go to the core with bus = secondary bus number, device = 1 and function 0. Requests on any other bus keep their own bus, device and function.
- R8: The core address word is laid out as follows: bit 31 = 1, bits 30:28 = 0, bits 27:24 = dword index bits 9:6, bits 23:16 = bus, bits 15:11 = device, bits 10:8 = function, bits 7:2 = dword index bits 5:0, bits 1:0 = 0. The byte enables and write data are passed through unchanged.
- R9: For a bridge read of dword 3, bits 22:16 of the core's data are replaced with 0x01. All other bits are returned unchanged.
- R10: After reset, shadow dword 7 reads 0x00000101, shadow dword 9 reads 0x00010001 and the other shadow dwords read 0. Both bus numbers are 0 and localDevNum is 1.
- R11: reqReady is low while a core access is outstanding. coreValid holds with a stable address until coreDone. Every accepted request gets exactly one rspValid pulse: in the cycle after acceptance for local requests, and in the cycle after coreDone for core requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Block can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBus | input | 8 | Target bus number |
| reqDev | input | 5 | Target device number |
| reqFunc | input | 3 | Target function number |
| reqDword | input | REG_W | Dword index into configuration space |
| reqBe | input | 4 | Byte enables |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | One-cycle completion pulse |
| rspRdata | output | 32 | Read data, valid with rspValid |
| coreValid | output | 1 | Core access outstanding |
| coreWrite | output | 1 | Core access is a write |
| coreAddr | output | 32 | Encoded core address word |
| coreBe | output | 4 | Core byte enables |
| coreWdata | output | 32 | Core write data |
| coreDone | input | 1 | Core completion pulse |
| coreRdata | input | 32 | Core read data, valid with coreDone |
| localBusNum | output | 8 | Local bus number driven to the core |
| localDevNum | output | 5 | Local device number driven to the core |

## Verification
The bench builds the block with its default parameters: a 10-bit dword index and local device 1. With these defaults, extended-offset bits 27:24 of the address word are reachable, and the shadow, ROM and bus-number dwords sit at their standard indices. The bench's core model answers after three cycles, which holds the block in its busy state long enough to see the ready gating. Reprogramming the primary and secondary bus numbers to different values moves the bridge's identity between buses, so both the legality rules and the bridge rewrite are exercised before and after each change.

// File: rtl/bcfPkg.sv
package bcfPkg;
  localparam int SH_LO      = 4;   // first shadowed dword (0x10)
  localparam int SH_N       = 9;   // shadowed dwords 0x10..0x33
  localparam int BAR0_DW    = 4;
  localparam int BUSNUM_DW  = 6;   // primary/secondary/subordinate
  localparam int IO_DW      = 7;
  localparam int PREF_DW    = 9;
  localparam int HDR_DW     = 3;
  localparam int ROM_DW     = 14;  // 0x38 as seen by host
  localparam int ROM_CORE_DW = 12; // 0x30 inside the core

  typedef enum logic [0:0] {ST_IDLE, ST_BUSY} stateT;

  typedef struct packed {
    logic takeLocal;
    logic takeCore;
    logic finish;
  } strobeT;

  function automatic logic [31:0] shadowInit(input int dw);
    if (dw == IO_DW)   return 32'h0000_0101;
    if (dw == PREF_DW) return 32'h0001_0001;
    return 32'h0;
  endfunction
endpackage

// File: rtl/bcfCtrl.sv
module bcfCtrl
  import bcfPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   isLocal,
  input  logic   coreDone,
  output logic   reqReady,
  output logic   coreValid,
  output logic   rspValid,
  output strobeT strobe
);
  stateT stateQ;
  logic  accept;

  assign reqReady  = (stateQ == ST_IDLE);
  assign coreValid = (stateQ == ST_BUSY);
  assign accept    = reqValid && reqReady;

  always_comb begin
    strobe.takeLocal = accept && isLocal;
    strobe.takeCore  = accept && !isLocal;
    strobe.finish    = (stateQ == ST_BUSY) && coreDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      rspValid <= 1'b0;
    end else begin
      rspValid <= strobe.takeLocal || strobe.finish;
      if (strobe.takeCore)    stateQ <= ST_BUSY;
      else if (strobe.finish) stateQ <= ST_IDLE;
    end
  end
endmodule

// File: rtl/bcfData.sv
module bcfData
  import bcfPkg::*;
#(
  parameter int REG_W     = 10,
  parameter int LOCAL_DEV = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqWrite,
  input  logic [7:0]       reqBus,
  input  logic [4:0]       reqDev,
  input  logic [2:0]       reqFunc,
  input  logic [REG_W-1:0] reqDword,
  input  logic [3:0]       reqBe,
  input  logic [31:0]      reqWdata,
  input  strobeT           strobe,
  input  logic [31:0]      coreRdata,
  output logic             isLocal,
  output logic [31:0]      rspRdata,
  output logic             coreWrite,
  output logic [31:0]      coreAddr,
  output logic [3:0]       coreBe,
  output logic [31:0]      coreWdata,
  output logic [7:0]       localBusNum
);
  localparam logic [REG_W-1:0] SH_LO_V  = REG_W'(SH_LO);
  localparam logic [REG_W-1:0] SH_HI_V  = REG_W'(SH_LO + SH_N);
  localparam logic [REG_W-1:0] ROM_V    = REG_W'(ROM_DW);
  localparam logic [REG_W-1:0] ROMC_V   = REG_W'(ROM_CORE_DW);
  localparam logic [REG_W-1:0] HDR_V    = REG_W'(HDR_DW);
  localparam logic [REG_W-1:0] BUSIDX_V = REG_W'(BUSNUM_DW - SH_LO);

  logic [31:0]      shadowQ [SH_N];
  logic [7:0]       primBusQ, secBusQ;
  logic             fixHdrQ;

  logic             isBridge, onSec, legal, aligned, inShadow;
  logic [REG_W-1:0] shDiff, coreDw;
  logic [31:0]      shRd, merged, localRdata, nextAddr;
  logic             shWe;
  logic [7:0]       tgtBus;
  logic [4:0]       tgtDev;
  logic [2:0]       tgtFunc;

  // request decode
  always_comb begin
    isBridge = (reqBus == primBusQ);
    onSec    = (reqBus == secBusQ);
    if (isBridge)   legal = (reqDev == 5'd0) && (reqFunc == 3'd0);
    else if (onSec) legal = (reqDev == 5'd0);
    else            legal = 1'b1;
    case (reqBe)
      4'b0001, 4'b0010, 4'b0100, 4'b1000,
      4'b0011, 4'b1100, 4'b1111: aligned = 1'b1;
      default:                   aligned = 1'b0;
    endcase
    inShadow = isBridge && (reqDword >= SH_LO_V) && (reqDword < SH_HI_V);
    isLocal  = !legal || !aligned || inShadow;
    shDiff   = reqDword - SH_LO_V;
  end

  // shadow read port and byte merge
  always_comb begin
    shRd = 32'h0;
    for (int i = 0; i < SH_N; i++)
      if (shDiff == REG_W'(i)) shRd = shadowQ[i];
    for (int b = 0; b < 4; b++)
      merged[8*b +: 8] = reqBe[b] ? reqWdata[8*b +: 8] : shRd[8*b +: 8];
    localRdata = (!legal || !aligned) ? 32'hFFFF_FFFF : shRd;
    shWe = strobe.takeLocal && legal && aligned && inShadow && reqWrite;
  end

  // shadow bank
  for (genvar g = 0; g < SH_N; g++) begin : gShadow
    localparam bit IS_BAR = (SH_LO + g == BAR0_DW) || (SH_LO + g == BAR0_DW + 1);
    always_ff @(posedge clk) begin
      if (!rstN)
        shadowQ[g] <= shadowInit(SH_LO + g);
      else if (shWe && shDiff == REG_W'(g))
        shadowQ[g] <= IS_BAR ? 32'h0 : merged;
    end
  end

  // bus-number tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      primBusQ <= 8'd0;
      secBusQ  <= 8'd0;
    end else if (shWe && shDiff == BUSIDX_V) begin
      if (reqBe[0]) primBusQ <= merged[7:0];
      if (reqBe[1]) secBusQ  <= merged[15:8];
    end
  end
  assign localBusNum = secBusQ;

  // address translation
  always_comb begin
    coreDw   = (isBridge && reqDword == ROM_V) ? ROMC_V : reqDword;
    tgtBus   = isBridge ? secBusQ : reqBus;
    tgtDev   = isBridge ? 5'(LOCAL_DEV) : reqDev;
    tgtFunc  = isBridge ? 3'd0 : reqFunc;
    nextAddr = {1'b1, 3'b000, 4'(coreDw >> 6), tgtBus, tgtDev, tgtFunc,
                coreDw[5:0], 2'b00};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coreAddr  <= 32'h0;
      coreBe    <= 4'h0;
      coreWdata <= 32'h0;
      coreWrite <= 1'b0;
      fixHdrQ   <= 1'b0;
    end else if (strobe.takeCore) begin
      coreAddr  <= nextAddr;
      coreBe    <= reqBe;
      coreWdata <= reqWdata;
      coreWrite <= reqWrite;
      fixHdrQ   <= isBridge && (reqDword == HDR_V) && !reqWrite;
    end
  end

  // response data
  always_ff @(posedge clk) begin
    if (!rstN)
      rspRdata <= 32'h0;
    else if (strobe.takeLocal)
      rspRdata <= localRdata;
    else if (strobe.finish)
      rspRdata <= fixHdrQ ? {coreRdata[31:23], 7'h01, coreRdata[15:0]} : coreRdata;
  end
endmodule

// File: rtl/bridgeCfgFront.sv
module bridgeCfgFront
  import bcfPkg::*;
#(
  parameter int REG_W     = 10,
  parameter int LOCAL_DEV = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqWrite,
  input  logic [7:0]       reqBus,
  input  logic [4:0]       reqDev,
  input  logic [2:0]       reqFunc,
  input  logic [REG_W-1:0] reqDword,
  input  logic [3:0]       reqBe,
  input  logic [31:0]      reqWdata,
  output logic             rspValid,
  output logic [31:0]      rspRdata,
  output logic             coreValid,
  output logic             coreWrite,
  output logic [31:0]      coreAddr,
  output logic [3:0]       coreBe,
  output logic [31:0]      coreWdata,
  input  logic             coreDone,
  input  logic [31:0]      coreRdata,
  output logic [7:0]       localBusNum,
  output logic [4:0]       localDevNum
);
  strobeT strobe;
  logic   isLocal;

  assign localDevNum = 5'(LOCAL_DEV);

  bcfCtrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .isLocal(isLocal),
    .coreDone(coreDone), .reqReady(reqReady), .coreValid(coreValid),
    .rspValid(rspValid), .strobe(strobe)
  );

  bcfData #(.REG_W(REG_W), .LOCAL_DEV(LOCAL_DEV)) uData (
    .clk(clk), .rstN(rstN), .reqWrite(reqWrite), .reqBus(reqBus),
    .reqDev(reqDev), .reqFunc(reqFunc), .reqDword(reqDword), .reqBe(reqBe),
    .reqWdata(reqWdata), .strobe(strobe), .coreRdata(coreRdata),
    .isLocal(isLocal), .rspRdata(rspRdata), .coreWrite(coreWrite),
    .coreAddr(coreAddr), .coreBe(coreBe), .coreWdata(coreWdata),
    .localBusNum(localBusNum)
  );
endmodule

// File: rtl/bridgeCfgFrontChk.sv
module bridgeCfgFrontChk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic        reqWrite,
  input logic        rspValid,
  input logic        coreValid,
  input logic        coreDone,
  input logic [31:0] coreAddr,
  input logic [7:0]  localBusNum
);
  // R11
  busy_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreValid |-> !reqReady);

  // R11
  core_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreValid && !coreDone) |=> (coreValid && $stable(coreAddr)));

  // R11
  rsp_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($past(reqValid && reqReady) || $past(coreValid && coreDone)));

  // R8
  addr_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreValid |-> (coreAddr[31] && coreAddr[30:28] == 3'b000 && coreAddr[1:0] == 2'b00));

  // R5
  busnum_by_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(localBusNum) |-> $past(reqValid && reqReady && reqWrite));
endmodule

bind bridgeCfgFront bridgeCfgFrontChk uChk (.*);

// File: tb/sim_bridgeCfgFront.sv
`timescale 1ns/1ps
module sim_bridgeCfgFront;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [7:0]  reqBus = '0;
  logic [4:0]  reqDev = '0;
  logic [2:0]  reqFunc = '0;
  logic [9:0]  reqDword = '0;
  logic [3:0]  reqBe = '0;
  logic [31:0] reqWdata = '0;
  logic        coreDone = 1'b0;
  logic [31:0] coreRdata = '0;
  logic        reqReady, rspValid, coreValid, coreWrite;
  logic [31:0] rspRdata, coreAddr, coreWdata;
  logic [3:0]  coreBe;
  logic [7:0]  localBusNum;
  logic [4:0]  localDevNum;

  int total = 0, bad = 0, rspSeen = 0;
  logic        expRd[$];
  logic [31:0] expData[$];
  string       expTag[$];
  logic [31:0] cAddrQ[$], cWdQ[$];
  logic        cWrQ[$];
  logic [3:0]  cBeQ[$];

  always #2 clk = ~clk;

  bridgeCfgFront u0 (.*);

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'h5A5A_C3C3;
  endfunction
  function automatic logic [31:0] hdrFix(input logic [31:0] d);
    return (d & ~32'h007F_0000) | 32'h0001_0000;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: pushes expectations, then issues the request
  task automatic doReq(input logic wr, input logic [7:0] bus, input logic [4:0] dev,
                       input logic [2:0] fn, input logic [9:0] dw, input logic [3:0] be,
                       input logic [31:0] wd, input logic toCore, input logic [31:0] cAddr,
                       input logic [31:0] expD, input string tag);
    int target;
    if (toCore) begin
      cAddrQ.push_back(cAddr); cWrQ.push_back(wr); cBeQ.push_back(be); cWdQ.push_back(wd);
    end
    expRd.push_back(!wr); expData.push_back(expD); expTag.push_back(tag);
    target = rspSeen + 1;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqBus = bus; reqDev = dev; reqFunc = fn;
    reqDword = dw; reqBe = be; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    while (rspSeen < target) @(negedge clk);
  endtask

  task automatic rdLocal(input logic [7:0] bus, input logic [4:0] dev, input logic [2:0] fn,
                         input logic [9:0] dw, input logic [3:0] be, input logic [31:0] expD,
                         input string tag);
    doReq(1'b0, bus, dev, fn, dw, be, 32'h0, 1'b0, 32'h0, expD, tag);
  endtask
  task automatic wrLocal(input logic [7:0] bus, input logic [9:0] dw, input logic [3:0] be,
                         input logic [31:0] wd, input string tag);
    doReq(1'b1, bus, 5'd0, 3'd0, dw, be, wd, 1'b0, 32'h0, 32'h0, tag);
  endtask

  // monitor: pops the scoreboard on each response
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expRd.size() == 0) chk(1'b0, "R11 unexpected response", 32'h1, 32'h0);
      else begin
        logic r; logic [31:0] d; string t;
        r = expRd.pop_front(); d = expData.pop_front(); t = expTag.pop_front();
        if (r) chk(rspRdata == d, t, rspRdata, d);
      end
      rspSeen++;
    end
  end

  // core model
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && coreValid) begin
        if (cAddrQ.size() == 0) chk(1'b0, "R1 R2 R3 unexpected core access", coreAddr, 32'h0);
        else begin
          logic [31:0] a, w; logic wr; logic [3:0] be;
          a = cAddrQ.pop_front(); wr = cWrQ.pop_front(); be = cBeQ.pop_front(); w = cWdQ.pop_front();
          chk(coreAddr == a, "R7 R8 core address", coreAddr, a);
          chk(coreWrite == wr && coreBe == be, "R8 core kind/enables", {27'h0, coreWrite, coreBe},
              {27'h0, wr, be});
          if (wr) chk(coreWdata == w, "R8 core wdata", coreWdata, w);
        end
        chk(!reqReady, "R11 ready low while busy", {31'h0, reqReady}, 32'h0);
        repeat (LAT - 1) @(negedge clk);
        chk(coreValid, "R11 coreValid held", {31'h0, coreValid}, 32'h1);
        coreRdata = pat(coreAddr);
        coreDone = 1'b1;
        @(negedge clk);
        coreDone = 1'b0;
      end
    end
  end

  initial begin
    #(4 * 100000);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(reqReady && !coreValid && !rspValid, "R10 R11 idle after reset",
        {29'h0, reqReady, coreValid, rspValid}, 32'h4);
    chk(localBusNum == 8'd0, "R10 local bus", {24'h0, localBusNum}, 32'h0);
    chk(localDevNum == 5'd1, "R10 local dev", {27'h0, localDevNum}, 32'h1);
    rdLocal(8'd0, 5'd0, 3'd0, 10'd7, 4'hF, 32'h0000_0101, "R10 io shadow");
    rdLocal(8'd0, 5'd0, 3'd0, 10'd9, 4'hF, 32'h0001_0001, "R10 pref shadow");
    rdLocal(8'd0, 5'd0, 3'd0, 10'd4, 4'hF, 32'h0, "R10 bar0 shadow");

    // R9 header type patch (bridge on bus 0 -> bus 0 dev 1)
    doReq(1'b0, 8'd0, 5'd0, 3'd0, 10'd3, 4'hF, 32'h0, 1'b1, 32'h8000_080C,
          hdrFix(pat(32'h8000_080C)), "R9 header type");

    // R5 bus numbers: primary 1, secondary 2
    wrLocal(8'd0, 10'd6, 4'hF, 32'h0005_0201, "R5 bus write");
    chk(localBusNum == 8'd2, "R5 local bus follows secondary", {24'h0, localBusNum}, 32'h2);

    // R7 bridge now on bus 1, forwarded to bus 2 dev 1
    doReq(1'b0, 8'd1, 5'd0, 3'd0, 10'd0, 4'hF, 32'h0, 1'b1, 32'h8002_0800,
          pat(32'h8002_0800), "R7 bridge remap");

    // R1 illegal requests
    rdLocal(8'd1, 5'd2, 3'd0, 10'd0, 4'hF, 32'hFFFF_FFFF, "R1 bridge dev!=0");
    rdLocal(8'd1, 5'd0, 3'd1, 10'd0, 4'hF, 32'hFFFF_FFFF, "R1 bridge func!=0");
    rdLocal(8'd2, 5'd3, 3'd0, 10'd0, 4'hF, 32'hFFFF_FFFF, "R1 secondary dev!=0");
    doReq(1'b1, 8'd2, 5'd1, 3'd0, 10'd1, 4'hF, 32'h1234_5678, 1'b0, 32'h0, 32'h0, "R1 dropped write");

    // R7 R8 passthrough with extended offset
    doReq(1'b0, 8'd2, 5'd0, 3'd3, 10'h045, 4'hF, 32'h0, 1'b1, 32'h8102_0314,
          pat(32'h8102_0314), "R8 extended offset");
    doReq(1'b1, 8'd5, 5'd7, 3'd2, 10'd1, 4'b0011, 32'hCAFE_BEEF, 1'b1, 32'h8005_3A04,
          32'h0, "R7 passthrough write");

    // R4 BARs read back zero
    wrLocal(8'd1, 10'd4, 4'hF, 32'hFFFF_FFFF, "R4 bar0 write");
    rdLocal(8'd1, 5'd0, 3'd0, 10'd4, 4'hF, 32'h0, "R4 bar0 zero");
    wrLocal(8'd1, 10'd5, 4'b0100, 32'h00FF_0000, "R4 bar1 write");
    rdLocal(8'd1, 5'd0, 3'd0, 10'd5, 4'hF, 32'h0, "R4 bar1 zero");

    // R3 byte merge
    wrLocal(8'd1, 10'd8, 4'b0011, 32'h1234_ABCD, "R3 low half");
    wrLocal(8'd1, 10'd8, 4'b1100, 32'h5678_0000, "R3 high half");
    rdLocal(8'd1, 5'd0, 3'd0, 10'd8, 4'hF, 32'h5678_ABCD, "R3 merged word");
    wrLocal(8'd1, 10'd7, 4'b0010, 32'h0000_F000, "R3 io byte");
    rdLocal(8'd1, 5'd0, 3'd0, 10'd7, 4'hF, 32'h0000_F001, "R3 io merge");

    // R6 ROM relocation
    doReq(1'b0, 8'd1, 5'd0, 3'd0, 10'd14, 4'hF, 32'h0, 1'b1, 32'h8002_0830,
          pat(32'h8002_0830), "R6 rom read");
    doReq(1'b1, 8'd1, 5'd0, 3'd0, 10'd14, 4'hF, 32'hDEAD_0001, 1'b1, 32'h8002_0830,
          32'h0, "R6 rom write");

    // R5 byte-wise updates
    wrLocal(8'd1, 10'd6, 4'b0010, 32'h0000_0700, "R5 secondary byte");
    chk(localBusNum == 8'd7, "R5 secondary byte", {24'h0, localBusNum}, 32'h7);
    rdLocal(8'd1, 5'd0, 3'd0, 10'd6, 4'hF, 32'h0005_0701, "R5 bus dword");
    wrLocal(8'd1, 10'd6, 4'b1100, 32'hAABB_0000, "R5 upper half");
    chk(localBusNum == 8'd7, "R5 upper half no effect", {24'h0, localBusNum}, 32'h7);
    wrLocal(8'd1, 10'd6, 4'b0001, 32'h0000_0003, "R5 primary byte");
    chk(localBusNum == 8'd7, "R5 primary leaves local", {24'h0, localBusNum}, 32'h7);
    doReq(1'b0, 8'd3, 5'd0, 3'd0, 10'd0, 4'hF, 32'h0, 1'b1, 32'h8007_0800,
          pat(32'h8007_0800), "R5 R7 new primary");
    doReq(1'b0, 8'd1, 5'd4, 3'd0, 10'd0, 4'hF, 32'h0, 1'b1, 32'h8001_2000,
          pat(32'h8001_2000), "R1 R7 old primary is ordinary");

    // R2 misaligned enables
    rdLocal(8'd3, 5'd0, 3'd0, 10'd0, 4'b0101, 32'hFFFF_FFFF, "R2 misaligned read");
    doReq(1'b1, 8'd3, 5'd0, 3'd0, 10'd8, 4'b0110, 32'h1111_1111, 1'b0, 32'h0, 32'h0,
          "R2 misaligned write");
    rdLocal(8'd3, 5'd0, 3'd0, 10'd8, 4'hF, 32'h5678_ABCD, "R2 shadow untouched");
    rdLocal(8'd3, 5'd0, 3'd0, 10'd8, 4'b0000, 32'hFFFF_FFFF, "R2 empty enables");

    repeat (5) @(negedge clk);
    chk(expRd.size() == 0 && cAddrQ.size() == 0, "R11 all requests completed",
        expRd.size() + cAddrQ.size(), 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule